// File: doc/BRIEF.md
# Streaming FFT Bit-Reversal Reorderer

This block takes a continuous stream of transform results that arrive in natural index order and sends them out again in bit-reversed index order, one sample per accepted input, with no gap between frames. The transform length N is a power of two that can be chosen at run time, from 16 points up to 2^MAX_LOG2 points (8192 with the default parameters). An upstream transform engine drives the input stream, and a downstream stage reads the output stream. A marker flags output index 0 of each frame.

The storage is two single-port banks, each N/2 words deep, so the total storage is N words. Successive frames swap between two address patterns: one frame writes each sample to the location given by its own index, and the next frame writes to the location given by the bit-reversed index. Each location is read out just before it is written again. Samples are handled in even/odd pairs. The two addresses of a pair always fall in different banks, so both banks read the pair in one cycle and write it in the next. Each bank port therefore does exactly one read or one write in any cycle, and the stream still moves one sample per cycle.

Everything advances only when an input is accepted. A cycle with no valid input stalls the whole pipeline, and the output stays invalid for that cycle.

Top module: `fft_bitrev_reorder`

## Requirements
- R1: When an output frame is produced, output sample k of that frame equals input sample bitrev_L(k) of the previous frame of the same length. Here L = log2(N), and bitrev_L reverses the low L bits of the index.
- R2: Once a previous frame of the same length exists, every accepted input produces exactly one valid output. Back-to-back frames pass with no idle output cycles.
- R3: Output index 0 of a frame is driven, with out_first_o high, in the cycle after the clock edge that accepts index 0 of the next frame. out_first_o is high for no other output.
- R4: Storage is two single-port banks of 2^(MAX_LOG2-1) words each. In any cycle, each bank performs one read, one write, or nothing. A write leaves that bank's read register unchanged.
- R5: The two addresses of a sample pair (indices 2m and 2m+1) fall in different banks, where bank = address bit 0 XOR address bit L-1. This holds in both the natural and the bit-reversed pattern.
- R6: len_log_i (N = 2^len_log_i) is sampled only on the edge that accepts index 0 of a frame. Changes to it in the middle of a frame have no effect on that frame's length or output order.
- R7: When the sampled length differs from the previous frame's length, the buffered frame is discarded. out_valid_o stays low for the whole first frame at the new length, and output resumes with the frame after it.
- R8: A len_log_i value below 4 selects 16 points. A value above MAX_LOG2 selects 2^MAX_LOG2 points.
- R9: A cycle with in_valid_i low produces out_valid_o low in the next cycle. It does not disturb the order or the content of later outputs.
- R10: After reset, out_valid_o and out_first_o are low, and the first frame after reset produces no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| len_log_i | input | LOG_W (4) | log2 of transform length, sampled at frame start |
| in_valid_i | input | 1 | Input sample valid |
| in_data_i | input | DATA_W | Input sample, natural order |
| out_valid_o | output | 1 | Output sample valid |
| out_first_o | output | 1 | Marks output index 0 of a frame |
| out_data_o | output | DATA_W | Output sample, bit-reversed order |

## Verification
A wrong frame counter or a wrong pattern bit breaks the mapping of every later frame. The errors then show as data mismatches starting at the first output of the next frame, that is, within N accepted samples. A bank-select or pair-hold fault corrupts alternate samples of the frame being written. The corruption becomes visible one frame later, when that frame is read out. Length and priming faults show at once in out_valid_o at the next frame boundary: either output that should have been suppressed after a length change appears, or output that should have appeared is missing.

// File: rtl/fft_bitrev_pkg.sv
package fft_bitrev_pkg;

    typedef enum logic [1:0] {
        BANK_IDLE  = 2'd0,
        BANK_READ  = 2'd1,
        BANK_WRITE = 2'd2
    } bank_op_e;

    function automatic int unsigned clamp_log(input int unsigned v,
                                              input int unsigned lo,
                                              input int unsigned hi);
        if (v < lo) return lo;
        if (v > hi) return hi;
        return v;
    endfunction

endpackage

// File: rtl/fft_bitrev_addr.sv
module fft_bitrev_addr #(
    parameter int unsigned MAX_LOG2 = 13,
    parameter int unsigned LOG_W    = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [MAX_LOG2-1:0]   idx_i,
    input  logic [LOG_W-1:0]      log_len_i,
    input  logic                  rev_pat_i,
    output logic [MAX_LOG2-2:0]   word_lo_o,
    output logic [MAX_LOG2-2:0]   word_hi_o,
    output logic                  bank_lo_o
);

    logic [MAX_LOG2-1:0] pos_lo, pos_hi;
    logic [MAX_LOG2-1:0] loc_lo, loc_hi;
    logic                bank_hi;

    function automatic logic [MAX_LOG2-1:0] rev_low(input logic [MAX_LOG2-1:0] v,
                                                    input int unsigned len);
        logic [MAX_LOG2-1:0] r;
        r = '0;
        for (int k = 0; k < MAX_LOG2; k++) begin
            for (int m = 0; m < MAX_LOG2; m++) begin
                if ((k < int'(len)) && (m == int'(len) - 1 - k)) r[k] = v[m];
            end
        end
        return r;
    endfunction

    function automatic logic bank_of(input logic [MAX_LOG2-1:0] a,
                                     input int unsigned len);
        logic top_bit;
        top_bit = 1'b0;
        for (int m = 0; m < MAX_LOG2; m++) begin
            if (m == int'(len) - 1) top_bit = a[m];
        end
        return a[0] ^ top_bit;
    endfunction

    always_comb begin
        pos_lo = {idx_i[MAX_LOG2-1:1], 1'b0};
        pos_hi = {idx_i[MAX_LOG2-1:1], 1'b1};
        loc_lo = rev_pat_i ? rev_low(pos_lo, int'(log_len_i)) : pos_lo;
        loc_hi = rev_pat_i ? rev_low(pos_hi, int'(log_len_i)) : pos_hi;
        bank_lo_o = bank_of(loc_lo, int'(log_len_i));
        bank_hi   = bank_of(loc_hi, int'(log_len_i));
        word_lo_o = loc_lo[MAX_LOG2-1:1];
        word_hi_o = loc_hi[MAX_LOG2-1:1];
    end

    // R5: the two halves of a pair never share a bank
    assert_pair_split_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (log_len_i != '0) |-> (bank_lo_o != bank_hi));

endmodule

// File: rtl/fft_bitrev_bank.sv
module fft_bitrev_bank
    import fft_bitrev_pkg::*;
#(
    parameter int unsigned AW     = 12,
    parameter int unsigned DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  bank_op_e          op_i,
    input  logic [AW-1:0]     addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [DATA_W-1:0] rdata_o
);

    localparam int unsigned DEPTH = 1 << AW;

    logic [DATA_W-1:0] mem_q [DEPTH];
    logic [DATA_W-1:0] rdata_q;

    always_ff @(posedge clk) begin
        if (op_i == BANK_WRITE) mem_q[addr_i] <= wdata_i;
        if (op_i == BANK_READ)  rdata_q <= mem_q[addr_i];
    end

    assign rdata_o = rdata_q;

    // R4: a write cycle leaves the single port's read register alone
    assert_write_keeps_rdata_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == BANK_WRITE) |=> $stable(rdata_o));

endmodule

// File: rtl/fft_bitrev_reorder.sv
module fft_bitrev_reorder
    import fft_bitrev_pkg::*;
#(
    parameter int unsigned MAX_LOG2 = 13,
    parameter int unsigned MIN_LOG2 = 4,
    parameter int unsigned DATA_W   = 16,
    parameter int unsigned LOG_W    = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [LOG_W-1:0]  len_log_i,
    input  logic              in_valid_i,
    input  logic [DATA_W-1:0] in_data_i,
    output logic              out_valid_o,
    output logic              out_first_o,
    output logic [DATA_W-1:0] out_data_o
);

    localparam int unsigned AW = MAX_LOG2 - 1;

    typedef struct packed {
        logic [MAX_LOG2-1:0] cnt;
        logic [LOG_W-1:0]    log_len;
        logic                rev_pat;
        logic                primed;
        logic                started;
        logic [DATA_W-1:0]   hold;
        logic                out_valid;
        logic                out_first;
        logic                out_bank;
    } state_t;

    state_t s_q, s_d;

    logic                at_start;
    logic                same_len;
    logic [LOG_W-1:0]    sel_log;
    logic [LOG_W-1:0]    frame_log;
    logic                frame_pat;
    logic                frame_primed;
    logic [MAX_LOG2:0]   frame_n;
    logic                frame_last;
    logic [AW-1:0]       word_lo, word_hi;
    logic                bank_lo;

    bank_op_e            op_d    [2];
    logic [AW-1:0]       addr_d  [2];
    logic [DATA_W-1:0]   wdata_d [2];
    logic [DATA_W-1:0]   rdata   [2];

    // frame-level decisions
    always_comb begin
        sel_log      = LOG_W'(clamp_log(int'(len_log_i), MIN_LOG2, MAX_LOG2));
        at_start     = (s_q.cnt == '0);
        same_len     = s_q.started && (sel_log == s_q.log_len);
        frame_log    = at_start ? sel_log : s_q.log_len;
        frame_pat    = at_start ? (same_len ? ~s_q.rev_pat : 1'b0) : s_q.rev_pat;
        frame_primed = at_start ? same_len : s_q.primed;
        frame_n      = (MAX_LOG2+1)'(1) << frame_log;
        frame_last   = ({1'b0, s_q.cnt} == frame_n - 1'b1);
    end

    fft_bitrev_addr #(
        .MAX_LOG2 (MAX_LOG2),
        .LOG_W    (LOG_W)
    ) i_addr (
        .clk       (clk),
        .rst_n     (rst_n),
        .idx_i     (s_q.cnt),
        .log_len_i (frame_log),
        .rev_pat_i (frame_pat),
        .word_lo_o (word_lo),
        .word_hi_o (word_hi),
        .bank_lo_o (bank_lo)
    );

    // bank access plan: even step reads the pair, odd step writes it back
    always_comb begin
        for (int b = 0; b < 2; b++) begin
            op_d[b]    = BANK_IDLE;
            addr_d[b]  = (1'(b) == bank_lo) ? word_lo : word_hi;
            wdata_d[b] = (1'(b) == bank_lo) ? s_q.hold : in_data_i;
            if (in_valid_i) op_d[b] = s_q.cnt[0] ? BANK_WRITE : BANK_READ;
        end
    end

    for (genvar g = 0; g < 2; g++) begin : g_bank
        fft_bitrev_bank #(
            .AW     (AW),
            .DATA_W (DATA_W)
        ) i_bank (
            .clk     (clk),
            .rst_n   (rst_n),
            .op_i    (op_d[g]),
            .addr_i  (addr_d[g]),
            .wdata_i (wdata_d[g]),
            .rdata_o (rdata[g])
        );
    end

    // next-state
    always_comb begin
        s_d           = s_q;
        s_d.out_valid = 1'b0;
        s_d.out_first = 1'b0;
        if (in_valid_i) begin
            s_d.cnt       = frame_last ? '0 : s_q.cnt + 1'b1;
            s_d.log_len   = frame_log;
            s_d.rev_pat   = frame_pat;
            s_d.primed    = frame_primed;
            s_d.started   = 1'b1;
            if (!s_q.cnt[0]) s_d.hold = in_data_i;
            s_d.out_valid = frame_primed;
            s_d.out_first = frame_primed && at_start;
            s_d.out_bank  = s_q.cnt[0] ? ~bank_lo : bank_lo;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q         <= '0;
            s_q.log_len <= LOG_W'(MIN_LOG2);
        end else begin
            s_q <= s_d;
        end
    end

    assign out_valid_o = s_q.out_valid;
    assign out_first_o = s_q.out_first;
    assign out_data_o  = rdata[s_q.out_bank];

    // R3: the frame marker only rides on a valid output, right after index 0
    assert_first_is_valid_R3: assert property (@(posedge clk) disable iff (!rst_n)
        out_first_o |-> (out_valid_o && s_q.cnt == MAX_LOG2'(1)));

    // R6: length is held for the whole frame
    assert_len_held_midframe_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.cnt != '0) |=> (s_q.log_len == $past(s_q.log_len)));

    // R7: no output from a frame that has no same-length predecessor
    assert_no_unprimed_out_R7: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid_o |-> s_q.primed);

    // R9: a stall cycle yields no output and freezes the counter
    assert_stall_freezes_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid_i |=> (!out_valid_o && $stable(s_q.cnt)));

    // R8: active length always within the supported range
    assert_len_in_range_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(s_q.log_len) >= int'(MIN_LOG2)) && (int'(s_q.log_len) <= int'(MAX_LOG2)));

endmodule

// File: tb/test_fft_bitrev_reorder.sv
module test_fft_bitrev_reorder;

    localparam int MAXL = 13;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  len_log = 4'd4;
    logic        in_valid = 1'b0;
    logic [15:0] in_data = '0;
    logic        out_valid, out_first;
    logic [15:0] out_data;

    fft_bitrev_reorder i_fft_bitrev_reorder (
        .clk         (clk),
        .rst_n       (rst_n),
        .len_log_i   (len_log),
        .in_valid_i  (in_valid),
        .in_data_i   (in_data),
        .out_valid_o (out_valid),
        .out_first_o (out_first),
        .out_data_o  (out_data)
    );

    always #10 clk = ~clk;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    logic [15:0] mem_b [2][8192];
    bit    m_started = 0;
    int    m_log = 4, m_idx = 0, m_wsel = 0;
    bit    m_primed = 0;
    bit    exp_valid = 0, exp_first = 0;
    logic [15:0] exp_data = '0;
    string vtag = "R10", dtag = "R1";

    function automatic int clampl(int v);
        if (v < 4) return 4;
        if (v > MAXL) return MAXL;
        return v;
    endfunction

    function automatic int brev(int v, int l);
        int r = 0;
        for (int k = 0; k < l; k++) if (v[k]) r |= 1 << (l - 1 - k);
        return r;
    endfunction

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
        end
    endtask

    task automatic check_outputs();
        chk(out_valid == exp_valid, vtag, out_valid, exp_valid);
        if (exp_valid) begin
            chk(out_first == exp_first, "R3", out_first, exp_first);
            chk(out_data == exp_data, dtag, out_data, exp_data);
        end
    endtask

    task automatic step(input bit v, input logic [15:0] d, input logic [3:0] sel,
                        input string vt, input string dt);
        check_outputs();
        in_valid = v;
        in_data  = d;
        len_log  = sel;
        vtag = vt;
        dtag = dt;
        if (v) begin
            if (m_idx == 0) begin
                int nl = clampl(int'(sel));
                m_primed = m_started && (nl == m_log);
                if (m_started) m_wsel ^= 1;
                m_log = nl;
                m_started = 1;
            end
            exp_valid = m_primed;
            exp_first = m_primed && (m_idx == 0);
            exp_data  = mem_b[m_wsel ^ 1][brev(m_idx, m_log)];
            mem_b[m_wsel][m_idx] = d;
            m_idx = (m_idx + 1 == (1 << m_log)) ? 0 : m_idx + 1;
        end else begin
            exp_valid = 0;
            exp_first = 0;
        end
        @(negedge clk);
    endtask

    task automatic run_frame(input int sel, input string vt, input string dt,
                             input int stall_pct, input bit midchange);
        int n = 1 << clampl(sel);
        logic [3:0] cur = 4'(sel);
        for (int i = 0; i < n; i++) begin
            while (int'($urandom_range(99)) < stall_pct)
                step(1'b0, 16'(($urandom)), cur, "R9", dt);
            if (midchange && i == n / 2) cur = 4'($urandom_range(15));
            step(1'b1, 16'($urandom), (i == 0) ? 4'(sel) : cur, vt, dt);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd12345));
        repeat (2) @(negedge clk);
        // R10: reset state
        chk(out_valid == 1'b0, "R10", out_valid, 0);
        chk(out_first == 1'b0, "R10", out_first, 0);
        rst_n = 1'b1;
        @(negedge clk);
        run_frame(4, "R10", "R1", 0, 0);
        run_frame(4, "R2", "R1", 0, 0);
        run_frame(4, "R9", "R1", 25, 0);
        run_frame(2, "R8", "R8", 0, 0);
        run_frame(5, "R7", "R5", 0, 0);
        run_frame(5, "R2", "R5", 10, 0);
        run_frame(8, "R7", "R1", 0, 0);
        run_frame(8, "R6", "R6", 10, 1);
        run_frame(8, "R6", "R6", 0, 1);
        run_frame(13, "R7", "R4", 0, 0);
        run_frame(15, "R8", "R4", 0, 0);
        run_frame(0, "R7", "R8", 0, 0);
        for (int f = 0; f < 6; f++) run_frame(4, "R2", "R1", 15, 0);
        step(1'b0, 16'h0, 4'd4, "R9", "R1");
        step(1'b0, 16'h0, 4'd4, "R9", "R1");
        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule